// File: doc/BRIEF.md
# Dual-Source Epoch Redirect Controller

This block decides, for a pipelined fetch front end, when the program counter must be reloaded and which in-flight instructions are on a wrong path. Two later stages can order a redirect: a decode stage that compares the fetched predicted-next PC with its own direction-based prediction, and an execute stage that resolves the true next PC. Each of these stages owns a one-bit epoch that flips whenever it redirects. Fetch keeps its own estimate of both epochs and stamps them on every instruction it issues. Decode also keeps an estimate of the execute epoch. Each stage compares the stamps with its own bits to decide whether an instruction is still live.

Execute redirects always win over decode redirects. A decode redirect that was issued on a path that execute has since abandoned is recognised at fetch, by its execute-epoch stamp, and thrown away. Instructions that execute kills are not silently lost. They leave the stage marked as poisoned, so that whatever tracks them downstream can still release their entries. Each redirect travels through its own one-entry queue inside the block.

Top module: `epoch_redirect_ctrl`

## Requirements
- R1: After reset every epoch bit is 0, both redirect queues are empty, the fetch PC equals the RESET_PC parameter, and fetch offers an instruction (f_valid_o = 1) with both stamps 0.
- R2: When no redirect is queued, fetch offers the current PC stamped with its execute-epoch estimate (f_eep_o) and its decode-epoch estimate (f_dep_o). On a cycle with f_valid_o and f_ready_i both high, the PC becomes f_ppc_i at the next edge. Otherwise it holds.
- R3: An execute instruction accepted with e_ieep_i different from the execute epoch raises e_poison_o. It never redirects and leaves the execute epoch unchanged.
- R4: An accepted, non-poisoned execute instruction with e_mispred_i high raises e_redirect_o, toggles the execute epoch and queues e_target_i. In the cycle after that, fetch loads e_target_i into the PC and toggles f_eep_o.
- R5: A decode instruction whose d_ieep_i differs from decode's execute-epoch estimate is kept (d_keep_o = 1). Decode copies d_ieep_i into that estimate and takes d_idep_i as its own epoch before any redirect toggle.
- R6: A decode instruction whose d_ieep_i matches decode's estimate but whose d_idep_i differs from the decode epoch is dropped (d_keep_o = 0). It causes no redirect and changes no state.
- R7: A kept decode instruction whose d_ppc_i differs from d_pred_i toggles the decode epoch. It queues d_pred_i, tagged with d_ieep_i as its execute-epoch stamp.
- R8: A dequeued decode redirect whose stamp equals f_eep_o loads the PC and toggles f_dep_o. A redirect whose stamp differs is consumed with PC and stamps unchanged.
- R9: When both queues hold a message, only the execute message is consumed in that cycle. The decode message stays queued.
- R10: f_valid_o is 0 in every cycle in which either redirect queue holds a message.
- R11: d_ready_o is 0 while the decode redirect queue is full, and e_ready_o is 0 while the execute redirect queue is full. A stalled stage consumes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| f_ppc_i | input | AW | Predicted next PC for the current fetch PC |
| f_ready_i | input | 1 | Fetch-to-decode buffer can take an instruction |
| f_valid_o | output | 1 | Fetch issues an instruction this cycle |
| f_pc_o | output | AW | Current fetch PC |
| f_eep_o | output | 1 | Execute-epoch stamp for the issued instruction |
| f_dep_o | output | 1 | Decode-epoch stamp for the issued instruction |
| d_valid_i | input | 1 | Decode holds an instruction |
| d_ready_o | output | 1 | Decode may consume its instruction |
| d_ppc_i | input | AW | Predicted next PC carried by the instruction |
| d_pred_i | input | AW | Decode-stage prediction of the next PC |
| d_ieep_i | input | 1 | Execute-epoch stamp of the decode instruction |
| d_idep_i | input | 1 | Decode-epoch stamp of the decode instruction |
| d_keep_o | output | 1 | Consumed instruction is live and goes on to execute |
| e_valid_i | input | 1 | Execute holds an instruction |
| e_ready_o | output | 1 | Execute may consume its instruction |
| e_ieep_i | input | 1 | Execute-epoch stamp of the execute instruction |
| e_mispred_i | input | 1 | Execute found the predicted next PC wrong |
| e_target_i | input | AW | Resolved next PC |
| e_poison_o | output | 1 | Consumed execute instruction is poisoned |
| e_redirect_o | output | 1 | Execute issues a redirect this cycle |

## Verification
The handshake outputs (d_keep_o, d_ready_o, e_poison_o, e_redirect_o, f_valid_o) depend on the current inputs and state in the same cycle. The bench therefore checks them just before the rising edge of the cycle in which the inputs were applied. A redirect is written into its queue at one edge and seen by fetch in the next cycle. f_pc_o and the fetch stamps change at the edge after that, two edges after the stage fired. The bench reproduces this with its own model, which it updates only at each edge, and compares every output with the model once per cycle, one nanosecond before the edge.

// File: rtl/epoch_pkg.sv
package epoch_pkg;

  // An instruction at decode survives when execute has moved on (a fresh
  // execute epoch resynchronises decode) or when its decode stamp is current.
  function automatic logic dec_survives(input logic ieep, input logic idep,
                                        input logic de_est, input logic d_ep);
    return (ieep != de_est) || (idep == d_ep);
  endfunction

  // Decode epoch after an accepted instruction, before the redirect toggle.
  function automatic logic dec_base_epoch(input logic ieep, input logic idep,
                                          input logic de_est, input logic d_ep);
    return (ieep != de_est) ? idep : d_ep;
  endfunction

  function automatic logic flip_if(input logic bit_in, input logic cond);
    return bit_in ^ cond;
  endfunction

endpackage

// File: rtl/redirect_slot.sv
module redirect_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enq_i,
  input  logic [W-1:0] data_i,
  input  logic         deq_i,
  output logic         full_o,
  output logic [W-1:0] data_o
);
  logic         full_q;
  logic [W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (deq_i) full_q <= 1'b0;
      if (enq_i) begin
        full_q <= 1'b1;
        data_q <= data_i;
      end
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  AST_NO_ENQ_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    enq_i |-> !full_q); // R11
endmodule

// File: rtl/fetch_epoch_unit.sv
module fetch_epoch_unit #(
  parameter int          AW       = 32,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] f_ppc_i,
  input  logic          f_ready_i,
  input  logic          xq_full_i,
  input  logic [AW-1:0] xq_pc_i,
  input  logic          dq_full_i,
  input  logic [AW-1:0] dq_pc_i,
  input  logic          dq_tag_i,
  output logic          xq_deq_o,
  output logic          dq_deq_o,
  output logic          f_valid_o,
  output logic [AW-1:0] f_pc_o,
  output logic          fe_ep_o,
  output logic          fd_ep_o
);
  logic [AW-1:0] pc_q;
  logic          fe_q, fd_q;
  logic          exe_take, dec_take, dec_apply, issue_fire;

  assign exe_take   = xq_full_i;
  assign dec_take   = dq_full_i && !xq_full_i;
  assign dec_apply  = dec_take && (dq_tag_i == fe_q);
  assign f_valid_o  = !xq_full_i && !dq_full_i;
  assign issue_fire = f_valid_o && f_ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q <= RESET_PC;
      fe_q <= 1'b0;
      fd_q <= 1'b0;
    end else if (exe_take) begin
      pc_q <= xq_pc_i;
      fe_q <= ~fe_q;
    end else if (dec_apply) begin
      pc_q <= dq_pc_i;
      fd_q <= ~fd_q;
    end else if (issue_fire) begin
      pc_q <= f_ppc_i;
    end
  end

  assign xq_deq_o = exe_take;
  assign dq_deq_o = dec_take;
  assign f_pc_o   = pc_q;
  assign fe_ep_o  = fe_q;
  assign fd_ep_o  = fd_q;

  AST_EXE_LOADS_PC: assert property (@(posedge clk) disable iff (!rst_n)
    xq_full_i |=> (pc_q == $past(xq_pc_i)) && (fe_q != $past(fe_q))); // R4
  AST_STALE_DEC_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_full_i && !xq_full_i && dq_tag_i != fe_q) |=> $stable(pc_q) && $stable(fd_q) && $stable(fe_q)); // R8
  AST_FETCH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (f_valid_o && f_ready_i) |=> (pc_q == $past(f_ppc_i))); // R2
endmodule

// File: rtl/decode_epoch_unit.sv
module decode_epoch_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  input  logic ieep_i,
  input  logic idep_i,
  input  logic pred_differs_i,
  output logic keep_o,
  output logic redir_o
);
  import epoch_pkg::*;
  logic de_q, d_q;
  logic survive, base;

  assign survive = dec_survives(ieep_i, idep_i, de_q, d_q);
  assign base    = dec_base_epoch(ieep_i, idep_i, de_q, d_q);
  assign keep_o  = fire_i && survive;
  assign redir_o = keep_o && pred_differs_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      de_q <= 1'b0;
      d_q  <= 1'b0;
    end else if (keep_o) begin
      de_q <= ieep_i;
      d_q  <= flip_if(base, pred_differs_i);
    end
  end

  AST_DROP_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && !keep_o) |=> $stable(de_q) && $stable(d_q)); // R6
  AST_KEEP_ADOPTS_EEP: assert property (@(posedge clk) disable iff (!rst_n)
    keep_o |=> (de_q == $past(ieep_i))); // R5
endmodule

// File: rtl/execute_epoch_unit.sv
module execute_epoch_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  input  logic ieep_i,
  input  logic mispred_i,
  output logic poison_o,
  output logic redir_o
);
  logic e_q;

  assign poison_o = fire_i && (ieep_i != e_q);
  assign redir_o  = fire_i && (ieep_i == e_q) && mispred_i;

  always_ff @(posedge clk) begin
    if (!rst_n) e_q <= 1'b0;
    else if (redir_o) e_q <= ~e_q;
  end

  AST_POISON_KEEPS_EPOCH: assert property (@(posedge clk) disable iff (!rst_n)
    poison_o |=> $stable(e_q)); // R3
endmodule

// File: rtl/epoch_redirect_ctrl.sv
module epoch_redirect_ctrl #(
  parameter int            AW       = 32,
  parameter logic [AW-1:0] RESET_PC = 32'h0000_1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] f_ppc_i,
  input  logic          f_ready_i,
  output logic          f_valid_o,
  output logic [AW-1:0] f_pc_o,
  output logic          f_eep_o,
  output logic          f_dep_o,
  input  logic          d_valid_i,
  output logic          d_ready_o,
  input  logic [AW-1:0] d_ppc_i,
  input  logic [AW-1:0] d_pred_i,
  input  logic          d_ieep_i,
  input  logic          d_idep_i,
  output logic          d_keep_o,
  input  logic          e_valid_i,
  output logic          e_ready_o,
  input  logic          e_ieep_i,
  input  logic          e_mispred_i,
  input  logic [AW-1:0] e_target_i,
  output logic          e_poison_o,
  output logic          e_redirect_o
);
  localparam int DQW = AW + 1;

  logic          xq_full, dq_full, xq_deq, dq_deq;
  logic [AW-1:0] xq_pc;
  logic [DQW-1:0] dq_word;
  logic          d_fire, e_fire, d_redir;

  assign d_ready_o = !dq_full;
  assign e_ready_o = !xq_full;
  assign d_fire    = d_valid_i && d_ready_o;
  assign e_fire    = e_valid_i && e_ready_o;

  redirect_slot #(.W(AW)) u_xq (
    .clk(clk), .rst_n(rst_n), .enq_i(e_redirect_o), .data_i(e_target_i),
    .deq_i(xq_deq), .full_o(xq_full), .data_o(xq_pc));

  redirect_slot #(.W(DQW)) u_dq (
    .clk(clk), .rst_n(rst_n), .enq_i(d_redir), .data_i({d_ieep_i, d_pred_i}),
    .deq_i(dq_deq), .full_o(dq_full), .data_o(dq_word));

  fetch_epoch_unit #(.AW(AW), .RESET_PC(RESET_PC)) u_fetch (
    .clk(clk), .rst_n(rst_n), .f_ppc_i(f_ppc_i), .f_ready_i(f_ready_i),
    .xq_full_i(xq_full), .xq_pc_i(xq_pc),
    .dq_full_i(dq_full), .dq_pc_i(dq_word[AW-1:0]), .dq_tag_i(dq_word[AW]),
    .xq_deq_o(xq_deq), .dq_deq_o(dq_deq),
    .f_valid_o(f_valid_o), .f_pc_o(f_pc_o), .fe_ep_o(f_eep_o), .fd_ep_o(f_dep_o));

  decode_epoch_unit u_dec (
    .clk(clk), .rst_n(rst_n), .fire_i(d_fire), .ieep_i(d_ieep_i),
    .idep_i(d_idep_i), .pred_differs_i(d_ppc_i != d_pred_i),
    .keep_o(d_keep_o), .redir_o(d_redir));

  execute_epoch_unit u_exe (
    .clk(clk), .rst_n(rst_n), .fire_i(e_fire), .ieep_i(e_ieep_i),
    .mispred_i(e_mispred_i), .poison_o(e_poison_o), .redir_o(e_redirect_o));

  AST_EXE_OVER_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (xq_full && dq_full) |=> dq_full); // R9
  AST_DEC_REDIR_TAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    d_redir |=> dq_full && (dq_word[AW] == $past(d_ieep_i)) && (dq_word[AW-1:0] == $past(d_pred_i))); // R7
  AST_NO_ISSUE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    $past(e_redirect_o) |-> !f_valid_o); // R10
endmodule

// File: tb/epoch_redirect_ctrl_test.sv
`timescale 1ns/1ps
module epoch_redirect_ctrl_test;
  localparam int AW = 32;
  localparam logic [AW-1:0] RPC = 32'h0000_1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] f_ppc_i = '0, d_ppc_i = '0, d_pred_i = '0, e_target_i = '0;
  logic f_ready_i = 0, d_valid_i = 0, d_ieep_i = 0, d_idep_i = 0;
  logic e_valid_i = 0, e_ieep_i = 0, e_mispred_i = 0;
  logic f_valid_o, f_eep_o, f_dep_o, d_ready_o, d_keep_o, e_ready_o, e_poison_o, e_redirect_o;
  logic [AW-1:0] f_pc_o;

  epoch_redirect_ctrl #(.AW(AW), .RESET_PC(RPC)) uut (.*);

  always #4 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0;
  bit done = 0;

  // reference model state
  logic [AW-1:0] m_pc, m_xpc, m_dpc;
  logic m_fe, m_fd, m_de, m_d, m_e, m_xv, m_dv, m_dtag;

  task automatic chk(input string req, input string what, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic m_survive(input logic ie, input logic id);
    if (ie != m_de) return 1'b1;
    return id == m_d;
  endfunction

  task automatic model_reset();
    m_pc = RPC; m_fe = 0; m_fd = 0; m_de = 0; m_d = 0; m_e = 0;
    m_xv = 0; m_dv = 0; m_dtag = 0; m_xpc = '0; m_dpc = '0;
  endtask

  // compare outputs against the model, just before the edge
  task automatic compare();
    logic ex_fv, ex_dk, ex_po, ex_er, dfire, efire;
    string r_pc;
    ex_fv = !m_xv && !m_dv;
    dfire = d_valid_i && !m_dv;
    efire = e_valid_i && !m_xv;
    ex_dk = dfire && m_survive(d_ieep_i, d_idep_i);
    ex_po = efire && (e_ieep_i != m_e);
    ex_er = efire && (e_ieep_i == m_e) && e_mispred_i;
    r_pc = "R2";
    chk("R10", "f_valid_o", AW'(f_valid_o), AW'(ex_fv));
    chk(r_pc, "f_pc_o", f_pc_o, m_pc);
    chk("R2", "f_eep_o", AW'(f_eep_o), AW'(m_fe));
    chk("R2", "f_dep_o", AW'(f_dep_o), AW'(m_fd));
    chk("R11", "d_ready_o", AW'(d_ready_o), AW'(!m_dv));
    chk("R11", "e_ready_o", AW'(e_ready_o), AW'(!m_xv));
    if (dfire && d_ieep_i != m_de) chk("R5", "d_keep_o", AW'(d_keep_o), AW'(ex_dk));
    else chk("R6", "d_keep_o", AW'(d_keep_o), AW'(ex_dk));
    chk("R3", "e_poison_o", AW'(e_poison_o), AW'(ex_po));
    chk("R4", "e_redirect_o", AW'(e_redirect_o), AW'(ex_er));
  endtask

  // advance the model by one edge with the present inputs
  task automatic model_step();
    logic dfire, efire, keep, diff, base, er;
    dfire = d_valid_i && !m_dv;
    efire = e_valid_i && !m_xv;
    keep  = dfire && m_survive(d_ieep_i, d_idep_i);
    diff  = d_ppc_i != d_pred_i;
    base  = (d_ieep_i != m_de) ? d_idep_i : m_d;
    er    = efire && (e_ieep_i == m_e) && e_mispred_i;
    // fetch (R4, R8, R9, R2)
    if (m_xv) begin m_pc = m_xpc; m_fe = ~m_fe; m_xv = 0; end
    else if (m_dv) begin
      if (m_dtag == m_fe) begin m_pc = m_dpc; m_fd = ~m_fd; end
      m_dv = 0;
    end else if (f_ready_i) m_pc = f_ppc_i;
    // decode (R5, R6, R7)
    if (keep) begin
      m_de = d_ieep_i;
      m_d  = base ^ diff;
      if (diff) begin m_dv = 1; m_dpc = d_pred_i; m_dtag = d_ieep_i; end
    end
    // execute (R3, R4)
    if (er) begin m_e = ~m_e; m_xv = 1; m_xpc = e_target_i; end
  endtask

  task automatic step();
    #3; compare();
    @(posedge clk); model_step();
    cyc++;
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    f_ready_i = 0; d_valid_i = 0; e_valid_i = 0; e_mispred_i = 0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    // R1: reset state
    #1;
    chk("R1", "f_pc_o reset", f_pc_o, RPC);
    chk("R1", "f_valid_o reset", AW'(f_valid_o), 1);
    chk("R1", "stamps reset", AW'({f_eep_o, f_dep_o}), 0);
    chk("R1", "ready reset", AW'({d_ready_o, e_ready_o}), 2'b11);
    @(negedge clk);

    // directed: execute mispredict and decode redirect together (R9, R7, R4)
    idle_inputs();
    e_valid_i = 1; e_ieep_i = 0; e_mispred_i = 1; e_target_i = 32'h0000_2000;
    d_valid_i = 1; d_ieep_i = 0; d_idep_i = 0; d_ppc_i = 32'h10; d_pred_i = 32'h40;
    step();
    idle_inputs();
    step();  // R9: only execute message consumed
    chk("R4", "pc after exe redirect", f_pc_o, 32'h0000_2000);
    step();  // stale decode redirect (tag 0, feEp now 1) consumed (R8)
    chk("R8", "stale dec ignored pc", f_pc_o, 32'h0000_2000);
    chk("R8", "stale dec fdEp", AW'(f_dep_o), 0);

    // directed: poisoned execute instruction (R3)
    e_valid_i = 1; e_ieep_i = 0; e_mispred_i = 1; e_target_i = 32'h99;
    step();
    idle_inputs();
    step();
    chk("R3", "pc not redirected by poison", f_pc_o, 32'h0000_2000);

    // constrained random phase
    for (int i = 0; i < 3000; i++) begin
      f_ready_i   = ($urandom % 4) != 0;
      f_ppc_i     = m_pc + 4;
      d_valid_i   = ($urandom % 3) != 0;
      d_ieep_i    = (($urandom % 4) == 0) ? ~m_de : m_de;
      d_idep_i    = (($urandom % 4) == 0) ? ~m_d : m_d;
      d_ppc_i     = 32'h100 + ($urandom % 4) * 4;
      d_pred_i    = (($urandom % 3) == 0) ? d_ppc_i + 32'h80 : d_ppc_i;
      e_valid_i   = ($urandom % 3) != 0;
      e_ieep_i    = (($urandom % 4) == 0) ? ~m_e : m_e;
      e_mispred_i = ($urandom % 5) == 0;
      e_target_i  = 32'h4000 + ($urandom % 64) * 4;
      step();
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule